// File: doc/BRIEF.md
# Sampled PI Current Regulator

This block closes the current loop for one phase of a switched reluctance drive. A slower supervisor loads a current set-point, and the block keeps it until the next load. The PWM timer raises a strobe once per switching period, at the centre of the symmetrical carrier. With each strobe comes a 12-bit phase-current sample. On that clock edge the block subtracts the sample from the held set-point. It then applies proportional and integral gains, scales the sum down by a power of two and saturates it. The result is an 8-bit duty word that the modulator can use directly.

The duty word carries a bipolar voltage demand in offset binary. The lowest code asks for the full negative bus voltage, the highest code asks for the full positive bus voltage, and the middle code asks for zero volts. Each sample is used as it arrives, with no filter in the loop. This is sound because the strobe falls where the switching ripple averages out. The integrator freezes whenever the output is already pinned in the direction the error pushes. Pulling the enable low parks the output at zero volts and empties the integrator.

Top module: `pi_current_reg`

## Requirements
- R1: After reset the duty output is 128, the integrator is zero and the held set-point is zero.
- R2: The duty word is offset binary: duty = clamp(u, -128, 127) + 128, where u is the signed scaled demand. Code 0 is full negative bus voltage, code 255 is full positive bus voltage and code 128 is zero volts.
- R3: A sample presented with `sample_strobe` high is reflected in `duty` right after the same rising clock edge. This is a one-cycle update. Without a strobe, `duty` stays unchanged.
- R4: `ref_in` is captured only on a clock edge with `ref_load` high. At other times changes on `ref_in` have no effect on the output. A strobe uses the set-point held before that edge.
- R5: The error is the held set-point minus the sample, treating both as unsigned 12-bit values. The result is a signed 13-bit value, and each update uses only the current sample.
- R6: On a strobe the candidate integrator is I + ki·e. The demand is u = (kp·e + candidate) arithmetically shifted right by `shift` bits. Both gains are unsigned 8-bit integers.
- R7: If u > 127 with e > 0, or u < -128 with e < 0, the integrator keeps its old value. Otherwise it takes the candidate.
- R8: While `en` is low the integrator is cleared and `duty` becomes 128 on the next edge, whatever the strobe does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Regulator enable; low parks the output and clears the integrator |
| ref_load | input | 1 | Capture strobe for the current set-point |
| ref_in | input | 12 | Current set-point, unsigned |
| sample_strobe | input | 1 | Centre-of-period sample strobe from the PWM timer |
| sample_in | input | 12 | Phase-current sample, unsigned |
| kp | input | 8 | Proportional gain, unsigned integer |
| ki | input | 8 | Integral gain, unsigned integer |
| shift | input | 4 | Right-shift applied to the PI sum (0 to 15) |
| duty | output | 8 | Offset-binary duty word for the modulator |

## Verification
The bench uses the default widths: 12-bit sample and set-point, 8-bit gains and duty word, 24-bit integrator and 4-bit shift. With these widths, full-scale errors and maximum gains drive the output to both rails, so both anti-windup branches get exercised. The shifts of 0, 2 and 4 it uses also let small errors land in the linear middle of the code range. Each of these shift values puts a different slice of the 25-bit sum into the duty word.

// File: rtl/pi_reg_pkg.sv
package pi_reg_pkg;

    // Default widths of the regulator datapath
    localparam int SAMPLE_W = 12;
    localparam int GAIN_W   = 8;
    localparam int DUTY_W   = 8;
    localparam int SHIFT_W  = 4;
    localparam int INT_W    = 24;

    // Saturation state of the scaled demand
    typedef enum logic [1:0] {
        SAT_NONE = 2'd0,
        SAT_HI   = 2'd1,
        SAT_LO   = 2'd2
    } sat_e;

    // Controls that gate a regulator step
    typedef struct packed {
        logic en;
        logic strobe;
    } step_ctl_t;

endpackage

// File: rtl/pi_ref_hold.sv
module pi_ref_hold #(
    parameter int SAMPLE_W = pi_reg_pkg::SAMPLE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] ref_in,
    output logic [SAMPLE_W-1:0] ref_q
);

    // Set-point is refreshed far more slowly than the loop runs
    always_ff @(posedge clk) begin
        if (rst)
            ref_q <= '0;
        else if (load)
            ref_q <= ref_in;
    end

endmodule

// File: rtl/pi_integrator.sv
module pi_integrator
    import pi_reg_pkg::*;
#(
    parameter int ERR_W  = pi_reg_pkg::SAMPLE_W + 1,
    parameter int GAIN_W = pi_reg_pkg::GAIN_W,
    parameter int INT_W  = pi_reg_pkg::INT_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  step_ctl_t               ctl,
    input  logic signed [ERR_W-1:0] err,
    input  logic [GAIN_W-1:0]       ki,
    input  sat_e                    sat,
    output logic signed [INT_W-1:0] integ_q,
    output logic signed [INT_W-1:0] integ_cand
);

    localparam int PROD_W = ERR_W + GAIN_W + 1;
    localparam int ACC_W  = INT_W + 1;
    localparam logic signed [ACC_W-1:0] I_MAX = {2'b00, {(INT_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] I_MIN = {2'b11, {(INT_W-1){1'b0}}};

    logic signed [PROD_W-1:0] inc;
    logic signed [ACC_W-1:0]  acc;
    logic                     hold;

    assign inc = err * $signed({1'b0, ki});
    assign acc = {integ_q[INT_W-1], integ_q}
               + {{(ACC_W-PROD_W){inc[PROD_W-1]}}, inc};

    // Keep the accumulator inside its own range
    always_comb begin
        if (acc > I_MAX)
            integ_cand = I_MAX[INT_W-1:0];
        else if (acc < I_MIN)
            integ_cand = I_MIN[INT_W-1:0];
        else
            integ_cand = acc[INT_W-1:0];
    end

    // Freeze when the output is already pinned the way the error pushes
    assign hold = ((sat == SAT_HI) && (err > 0)) || ((sat == SAT_LO) && (err < 0));

    always_ff @(posedge clk) begin
        if (rst || !ctl.en)
            integ_q <= '0;
        else if (ctl.strobe && !hold)
            integ_q <= integ_cand;
    end

endmodule

// File: rtl/pi_output_stage.sv
module pi_output_stage
    import pi_reg_pkg::*;
#(
    parameter int ERR_W   = pi_reg_pkg::SAMPLE_W + 1,
    parameter int GAIN_W  = pi_reg_pkg::GAIN_W,
    parameter int INT_W   = pi_reg_pkg::INT_W,
    parameter int SHIFT_W = pi_reg_pkg::SHIFT_W,
    parameter int DUTY_W  = pi_reg_pkg::DUTY_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  step_ctl_t               ctl,
    input  logic signed [ERR_W-1:0] err,
    input  logic [GAIN_W-1:0]       kp,
    input  logic [SHIFT_W-1:0]      shift,
    input  logic signed [INT_W-1:0] integ_cand,
    output sat_e                    sat,
    output logic [DUTY_W-1:0]       duty
);

    localparam int PROD_W = ERR_W + GAIN_W + 1;
    localparam int SUM_W  = INT_W + 1;
    localparam logic signed [SUM_W-1:0] U_MAX = SUM_W'((1 << (DUTY_W-1)) - 1);
    localparam logic signed [SUM_W-1:0] U_MIN = -SUM_W'(1 << (DUTY_W-1));
    localparam logic [DUTY_W-1:0] MID = {1'b1, {(DUTY_W-1){1'b0}}};

    logic signed [PROD_W-1:0] prop;
    logic signed [SUM_W-1:0]  sum;
    logic signed [SUM_W-1:0]  scaled;
    logic [DUTY_W-1:0]        u_sat;
    logic [DUTY_W-1:0]        duty_next;

    assign prop   = err * $signed({1'b0, kp});
    assign sum    = {integ_cand[INT_W-1], integ_cand}
                  + {{(SUM_W-PROD_W){prop[PROD_W-1]}}, prop};
    assign scaled = sum >>> shift;

    always_comb begin
        if (scaled > U_MAX) begin
            sat   = SAT_HI;
            u_sat = U_MAX[DUTY_W-1:0];
        end else if (scaled < U_MIN) begin
            sat   = SAT_LO;
            u_sat = U_MIN[DUTY_W-1:0];
        end else begin
            sat   = SAT_NONE;
            u_sat = scaled[DUTY_W-1:0];
        end
    end

    // Two's complement to offset binary: invert the sign bit
    assign duty_next = {~u_sat[DUTY_W-1], u_sat[DUTY_W-2:0]};

    always_ff @(posedge clk) begin
        if (rst || !ctl.en)
            duty <= MID;
        else if (ctl.strobe)
            duty <= duty_next;
    end

endmodule

// File: rtl/pi_current_reg.sv
module pi_current_reg
    import pi_reg_pkg::*;
#(
    parameter int SAMPLE_W = pi_reg_pkg::SAMPLE_W,
    parameter int GAIN_W   = pi_reg_pkg::GAIN_W,
    parameter int DUTY_W   = pi_reg_pkg::DUTY_W,
    parameter int SHIFT_W  = pi_reg_pkg::SHIFT_W,
    parameter int INT_W    = pi_reg_pkg::INT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                ref_load,
    input  logic [SAMPLE_W-1:0] ref_in,
    input  logic                sample_strobe,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [GAIN_W-1:0]   kp,
    input  logic [GAIN_W-1:0]   ki,
    input  logic [SHIFT_W-1:0]  shift,
    output logic [DUTY_W-1:0]   duty
);

    localparam int ERR_W = SAMPLE_W + 1;

    logic [SAMPLE_W-1:0]     ref_q;
    logic signed [ERR_W-1:0] err;
    logic signed [INT_W-1:0] integ_q;
    logic signed [INT_W-1:0] integ_cand;
    sat_e                    sat;
    step_ctl_t               ctl;

    assign ctl.en     = en;
    assign ctl.strobe = sample_strobe;

    pi_ref_hold #(.SAMPLE_W(SAMPLE_W)) u_ref (
        .clk    (clk),
        .rst    (rst),
        .load   (ref_load),
        .ref_in (ref_in),
        .ref_q  (ref_q)
    );

    // Unfiltered error, set-point minus feedback
    assign err = $signed({1'b0, ref_q}) - $signed({1'b0, sample_in});

    pi_integrator #(.ERR_W(ERR_W), .GAIN_W(GAIN_W), .INT_W(INT_W)) u_int (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .err        (err),
        .ki         (ki),
        .sat        (sat),
        .integ_q    (integ_q),
        .integ_cand (integ_cand)
    );

    pi_output_stage #(
        .ERR_W(ERR_W), .GAIN_W(GAIN_W), .INT_W(INT_W),
        .SHIFT_W(SHIFT_W), .DUTY_W(DUTY_W)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .err        (err),
        .kp         (kp),
        .shift      (shift),
        .integ_cand (integ_cand),
        .sat        (sat),
        .duty       (duty)
    );

endmodule

// File: rtl/pi_current_reg_chk.sv
module pi_current_reg_chk
    import pi_reg_pkg::*;
#(
    parameter int SAMPLE_W = pi_reg_pkg::SAMPLE_W,
    parameter int DUTY_W   = pi_reg_pkg::DUTY_W,
    parameter int INT_W    = pi_reg_pkg::INT_W
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      en,
    input logic                      sample_strobe,
    input logic                      ref_load,
    input logic [SAMPLE_W-1:0]       ref_in,
    input logic [SAMPLE_W-1:0]       ref_q,
    input logic signed [SAMPLE_W:0]  err,
    input logic signed [INT_W-1:0]   integ_q,
    input sat_e                      sat,
    input logic [DUTY_W-1:0]         duty
);

    localparam logic [DUTY_W-1:0] MID = {1'b1, {(DUTY_W-1){1'b0}}};

    // R8: disabled regulator parks at zero volts
    a_r8_park_mid: assert property (@(posedge clk) disable iff (rst)
        !en |=> duty == MID);

    // R8: disabled regulator empties its integrator
    a_r8_clear_int: assert property (@(posedge clk) disable iff (rst)
        !en |=> integ_q == '0);

    // R3: no strobe, no change of the duty word
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (en && !sample_strobe) |=> $stable(duty));

    // R7: anti-windup on the upper rail
    a_r7_freeze_hi: assert property (@(posedge clk) disable iff (rst)
        (en && sample_strobe && sat == SAT_HI && err > 0) |=> $stable(integ_q));

    // R7: anti-windup on the lower rail
    a_r7_freeze_lo: assert property (@(posedge clk) disable iff (rst)
        (en && sample_strobe && sat == SAT_LO && err < 0) |=> $stable(integ_q));

    // R2: upper saturation gives the top code
    a_r2_top_code: assert property (@(posedge clk) disable iff (rst)
        (en && sample_strobe && sat == SAT_HI) |=> duty == '1);

    // R2: lower saturation gives the bottom code
    a_r2_bottom_code: assert property (@(posedge clk) disable iff (rst)
        (en && sample_strobe && sat == SAT_LO) |=> duty == '0);

    // R4: set-point only moves on a load
    a_r4_ref_kept: assert property (@(posedge clk) disable iff (rst)
        !ref_load |=> $stable(ref_q));

    a_r4_ref_taken: assert property (@(posedge clk) disable iff (rst)
        ref_load |=> ref_q == $past(ref_in));

endmodule

bind pi_current_reg pi_current_reg_chk #(
    .SAMPLE_W(SAMPLE_W), .DUTY_W(DUTY_W), .INT_W(INT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .en            (en),
    .sample_strobe (sample_strobe),
    .ref_load      (ref_load),
    .ref_in        (ref_in),
    .ref_q         (ref_q),
    .err           (err),
    .integ_q       (integ_q),
    .sat           (sat),
    .duty          (duty)
);

// File: tb/sim_pi_current_reg.sv
module sim_pi_current_reg;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // {set-point 12, sample 12, kp 8, ki 8, shift 4, en 1}
    localparam logic [44:0] VEC [NVEC] = '{
        {12'd2000, 12'd1900, 8'd16,  8'd1,   4'd4, 1'b1},
        {12'd2000, 12'd1950, 8'd16,  8'd1,   4'd4, 1'b1},
        {12'd1500, 12'd1600, 8'd16,  8'd1,   4'd4, 1'b1},
        {12'd3000, 12'd1000, 8'd16,  8'd1,   4'd4, 1'b1},
        {12'd3000, 12'd1000, 8'd16,  8'd1,   4'd4, 1'b1},
        {12'd1000, 12'd3000, 8'd16,  8'd1,   4'd4, 1'b1},
        {12'd2048, 12'd2048, 8'd0,   8'd0,   4'd4, 1'b1},
        {12'd4095, 12'd0,    8'd255, 8'd255, 4'd0, 1'b1},
        {12'd0,    12'd4095, 8'd255, 8'd255, 4'd0, 1'b1},
        {12'd100,  12'd50,   8'd8,   8'd2,   4'd2, 1'b0},
        {12'd100,  12'd50,   8'd8,   8'd2,   4'd2, 1'b1},
        {12'd2000, 12'd2000, 8'd0,   8'd0,   4'd0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b1;
    logic        ref_load = 1'b0;
    logic [11:0] ref_in = '0;
    logic        sample_strobe = 1'b0;
    logic [11:0] sample_in = '0;
    logic [7:0]  kp = '0;
    logic [7:0]  ki = '0;
    logic [3:0]  shift = '0;
    logic [7:0]  duty;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 1'b0;
    longint m_integ = 0;
    longint m_ref = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pi_current_reg u0 (
        .clk(clk), .rst(rst), .en(en), .ref_load(ref_load), .ref_in(ref_in),
        .sample_strobe(sample_strobe), .sample_in(sample_in),
        .kp(kp), .ki(ki), .shift(shift), .duty(duty)
    );

    task automatic check(input string req, input int act, input int exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_errors++;
            $display("FAIL %s: duty=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Independent model of one regulator step (R5, R6, R7, R2, R8)
    function automatic int model_step(input longint meas, input longint kp_v,
                                      input longint ki_v, input int sh, input bit en_v);
        longint e, cand, u;
        if (!en_v) begin
            m_integ = 0;
            return 128;
        end
        e    = m_ref - meas;
        cand = m_integ + ki_v * e;
        if (cand > 64'sd8388607)  cand = 64'sd8388607;
        if (cand < -64'sd8388608) cand = -64'sd8388608;
        u = (kp_v * e + cand) >>> sh;
        if (!((u > 127 && e > 0) || (u < -128 && e < 0)))
            m_integ = cand;
        if (u > 127)  u = 127;
        if (u < -128) u = -128;
        return int'(u) + 128;
    endfunction

    task automatic load_ref(input logic [11:0] v);
        @(negedge clk);
        ref_in = v;
        ref_load = 1'b1;
        @(negedge clk);
        ref_load = 1'b0;
        m_ref = longint'(v);
    endtask

    // Strobe one sample; duty is checked on the following negedge
    task automatic strobe(input logic [11:0] meas);
        @(negedge clk);
        sample_in = meas;
        sample_strobe = 1'b1;
        @(negedge clk);
        sample_strobe = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 reset duty", duty, 128);

        // Table walk (R2, R5, R6, R7, R8)
        for (int i = 0; i < NVEC; i++) begin
            int exp_d;
            load_ref(VEC[i][44:33]);
            kp = VEC[i][20:13];
            ki = VEC[i][12:5];
            shift = VEC[i][4:1];
            en = VEC[i][0];
            exp_d = model_step(longint'(VEC[i][32:21]), longint'(VEC[i][20:13]),
                               longint'(VEC[i][12:5]), int'(VEC[i][4:1]), VEC[i][0]);
            strobe(VEC[i][32:21]);
            check($sformatf("R6 R7 R2 vector %0d", i), duty, exp_d);
            en = 1'b1;
        end

        // R3: sample changes without strobe leave duty untouched
        begin
            int held;
            held = duty;
            kp = 8'd40; ki = 8'd3; shift = 4'd1;
            sample_in = 12'd0;
            repeat (4) @(negedge clk);
            check("R3 no strobe hold", duty, held);
        end

        // R4: set-point change without load is ignored
        begin
            int exp_d;
            load_ref(12'd2000);
            kp = 8'd16; ki = 8'd0; shift = 4'd4;
            @(negedge clk);
            ref_in = 12'd4000;
            exp_d = model_step(64'd1990, 64'd16, 64'd0, 4, 1'b1);
            strobe(12'd1990);
            check("R4 unloaded set-point ignored", duty, exp_d);
        end

        // R7: drive windup hard, then a zero error shows the frozen integrator
        begin
            int exp_d;
            load_ref(12'd3500);
            kp = 8'd2; ki = 8'd10; shift = 4'd4;
            for (int k = 0; k < 6; k++) begin
                exp_d = model_step(64'd500, 64'd2, 64'd10, 4, 1'b1);
                strobe(12'd500);
            end
            check("R7 saturated high", duty, exp_d);
            kp = 8'd0; ki = 8'd0;
            exp_d = model_step(64'd3500, 64'd0, 64'd0, 4, 1'b1);
            strobe(12'd3500);
            check("R7 integrator frozen", duty, exp_d);
        end

        // R8: enable low without strobe parks output and clears integrator
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check("R8 park mid", duty, 128);
        en = 1'b1;
        kp = 8'd0; ki = 8'd0; shift = 4'd0;
        m_integ = 0;
        strobe(12'd100);
        check("R8 integrator cleared", duty, 128);

        // R3: one-cycle update seen right after the strobe edge
        begin
            int exp_d;
            load_ref(12'd1000);
            kp = 8'd1; ki = 8'd0; shift = 4'd0;
            exp_d = model_step(64'd990, 64'd1, 64'd0, 0, 1'b1);
            strobe(12'd990);
            check("R3 single cycle update", duty, exp_d);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule